// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block runs one complete mailbox command against a remote controller, reaching it through a simple byte-wide register access port. A requester hands over a command code, a 32-bit operand and a flag that says whether the command returns data. The sequencer arms the mailbox, loads the command and operand, and rings the doorbell. It then polls a status byte until the remote side reports completion, spacing the polls by a programmable number of cycles. For commands that return data it collects four result bytes. Finally it acknowledges completion by writing the completion bit back.

The register port carries one access at a time. The sequencer raises a request with address, direction and write data, and holds them until the responder returns an acknowledge. An acknowledge that comes with an error indication ends the command at once. The outcome is a single done pulse carrying two error flags and the assembled result.

Top module: `mbox_seq`

## Requirements
- R1: A request on `cmd_valid` is taken only while the sequencer is idle, and requests seen while busy are ignored. `busy` rises the cycle after acceptance and stays high until `done` pulses for exactly one cycle, when `busy` is low.
- R2: For both command kinds the first register writes occur in this order: 0x80 to address 0x3F, the command code to 0x38, operand bytes 0 to 3 (least significant first) to 0x39 to 0x3C, then 0x01 to 0x40.
- R3: While `reg_req` is high and no `reg_ack` has arrived, the sequencer holds `reg_addr`, `reg_we` and `reg_wdata` unchanged. It drops `reg_req` in the cycle after an acknowledge. No access is requested while idle.
- R4: After the doorbell, the sequencer reads address 0x02 and treats bit 1 as the completion flag. Between a status read that finds the flag clear and the next status request, at least `poll_gap` cycles pass.
- R5: If the flag is still clear after one poll plus `RETRIES` further polls (11 reads by default), the command ends with `err_timeout`. No result read and no acknowledge write are made.
- R6: For a read command, after completion the sequencer reads addresses 0x31, 0x32, 0x33 and 0x34 and places them in `result` from least significant byte upward.
- R7: Once completion is seen (and after any result reads), the sequencer writes the last status value it read, with bit 1 forced to 1, back to address 0x02. It then ends without error.
- R8: An acknowledge that comes with `reg_err` ends the command with `err_bus` on the next `done`, and no further access is requested.
- R9: `err_bus` and `err_timeout` are high only together with `done` and never both at once. `result` is zero for write commands and for every failed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request strobe for a new command |
| cmd_code | input | 8 | Command code |
| cmd_opnd | input | 32 | Input operand |
| cmd_read | input | 1 | High when the command returns data |
| poll_gap | input | GAP_W | Minimum idle cycles between status polls |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_bus | output | 1 | Command ended by a failed register access |
| err_timeout | output | 1 | Completion flag never appeared |
| result | output | 32 | Returned data, valid with done |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | High for a write access |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | Access complete |
| reg_err | input | 1 | Access failed, valid with reg_ack |
| reg_rdata | input | 8 | Read data, valid with reg_ack |

## Verification
The assertions assume that the responder asserts `reg_ack` only while `reg_req` is high, for one cycle per access, and that `reg_err` and `reg_rdata` are meaningful only in that cycle. They also assume that `cmd_valid` is a single-cycle strobe. The bench responder starts counting its latency only on a request it has not yet answered, and always clears the acknowledge on the following cycle. The bench drives each request strobe for one cycle at the falling edge. The remote side's completion flag is raised only after the doorbell write, so that status values in the model match what a real mailbox would report.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_POLL,
    ST_GAP,
    ST_FETCH,
    ST_ACK
  } seq_st_t;

  localparam logic [7:0] ADR_STATUS  = 8'h02;
  localparam logic [7:0] ADR_OUT_LO  = 8'h31;
  localparam logic [7:0] ADR_IN_CMD  = 8'h38;
  localparam logic [7:0] ADR_IN_OPND = 8'h39;
  localparam logic [7:0] ADR_IN_ARM  = 8'h3F;
  localparam logic [7:0] ADR_BELL    = 8'h40;

  localparam logic [7:0] ARM_VALUE   = 8'h80;
  localparam logic [7:0] BELL_VALUE  = 8'h01;
  localparam int         FLAG_BIT    = 1;

endpackage

// File: rtl/mbox_step_decode.sv
module mbox_step_decode
  import mbox_seq_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int STEP_W = $clog2(NBYTES + 3)
) (
  input  logic [STEP_W-1:0]   step,
  input  logic [7:0]          code,
  input  logic [8*NBYTES-1:0] opnd,
  output logic [7:0]          addr,
  output logic [7:0]          wdata,
  output logic                last
);

  localparam int LAST_STEP = NBYTES + 2;

  logic [STEP_W-1:0] byte_idx;

  always_comb begin
    byte_idx = step - STEP_W'(2);
    last     = (step == STEP_W'(LAST_STEP));
    if (step == '0) begin
      addr  = ADR_IN_ARM;
      wdata = ARM_VALUE;
    end else if (step == STEP_W'(1)) begin
      addr  = ADR_IN_CMD;
      wdata = code;
    end else if (step < STEP_W'(LAST_STEP)) begin
      addr  = ADR_IN_OPND + 8'(byte_idx);
      wdata = opnd[8*byte_idx +: 8];
    end else begin
      addr  = ADR_BELL;
      wdata = BELL_VALUE;
    end
  end

endmodule

// File: rtl/mbox_gap_timer.sv
module mbox_gap_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [GAP_W-1:0] len,
  output logic             expired
);

  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len;
    end else if (cnt != '0) begin
      cnt <= cnt - GAP_W'(1);
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/mbox_byte_gather.sv
module mbox_byte_gather #(
  parameter int NBYTES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                shift,
  input  logic [7:0]          din,
  output logic [8*NBYTES-1:0] word
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      word <= '0;
    end else if (shift) begin
      word <= {din, word[8*NBYTES-1:8]};
    end
  end

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_seq_pkg::*;
#(
  parameter int NBYTES  = 4,
  parameter int RETRIES = 10,
  parameter int GAP_W   = 16,
  localparam int OPND_W = 8 * NBYTES,
  localparam int STEP_W = $clog2(NBYTES + 3),
  localparam int TRY_W  = $clog2(RETRIES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [OPND_W-1:0] cmd_opnd,
  input  logic              cmd_read,
  input  logic [GAP_W-1:0]  poll_gap,
  output logic              busy,
  output logic              done,
  output logic              err_bus,
  output logic              err_timeout,
  output logic [OPND_W-1:0] result,
  output logic              reg_req,
  output logic              reg_we,
  output logic [7:0]        reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic              reg_ack,
  input  logic              reg_err,
  input  logic [7:0]        reg_rdata
);

  seq_st_t           st;
  logic [7:0]        code_q;
  logic [OPND_W-1:0] opnd_q;
  logic              rd_q;
  logic [STEP_W-1:0] step;
  logic [TRY_W-1:0]  tries;
  logic [7:0]        stat_q;

  logic [7:0]        dec_addr, dec_wdata;
  logic              dec_last;
  logic              gap_expired;
  logic [OPND_W-1:0] gathered;

  logic acc_done, acc_ok, flag_seen;
  logic fin_bus, fin_to, fin_ok, fin_any;
  logic accept, gap_load, fetch_shift;

  assign acc_done  = reg_req && reg_ack;
  assign acc_ok    = acc_done && !reg_err;
  assign flag_seen = reg_rdata[FLAG_BIT];

  assign accept      = (st == ST_IDLE) && cmd_valid;
  assign fin_bus     = acc_done && reg_err;
  assign fin_to      = (st == ST_POLL) && acc_ok && !flag_seen
                       && (tries == TRY_W'(RETRIES));
  assign fin_ok      = (st == ST_ACK) && acc_ok;
  assign fin_any     = fin_bus || fin_to || fin_ok;
  assign gap_load    = (st == ST_POLL) && acc_ok && !flag_seen
                       && (tries != TRY_W'(RETRIES));
  assign fetch_shift = (st == ST_FETCH) && acc_ok;

  mbox_step_decode #(.NBYTES(NBYTES)) u_dec (
    .step  (step),
    .code  (code_q),
    .opnd  (opnd_q),
    .addr  (dec_addr),
    .wdata (dec_wdata),
    .last  (dec_last)
  );

  mbox_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .load    (gap_load),
    .len     (poll_gap),
    .expired (gap_expired)
  );

  mbox_byte_gather #(.NBYTES(NBYTES)) u_gather (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .shift (fetch_shift),
    .din   (reg_rdata),
    .word  (gathered)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      code_q      <= '0;
      opnd_q      <= '0;
      rd_q        <= 1'b0;
      step        <= '0;
      tries       <= '0;
      stat_q      <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      err_bus     <= 1'b0;
      err_timeout <= 1'b0;
      result      <= '0;
      reg_req     <= 1'b0;
      reg_we      <= 1'b0;
      reg_addr    <= '0;
      reg_wdata   <= '0;
    end else begin
      done        <= 1'b0;
      err_bus     <= 1'b0;
      err_timeout <= 1'b0;
      if (fin_any) begin
        st          <= ST_IDLE;
        reg_req     <= 1'b0;
        busy        <= 1'b0;
        done        <= 1'b1;
        err_bus     <= fin_bus;
        err_timeout <= fin_to;
        result      <= (fin_ok && rd_q) ? gathered : '0;
      end else begin
        unique case (st)
          ST_IDLE: begin
            if (cmd_valid) begin
              code_q <= cmd_code;
              opnd_q <= cmd_opnd;
              rd_q   <= cmd_read;
              step   <= '0;
              tries  <= '0;
              busy   <= 1'b1;
              st     <= ST_LOAD;
            end
          end
          ST_LOAD: begin
            if (!reg_req) begin
              reg_req   <= 1'b1;
              reg_we    <= 1'b1;
              reg_addr  <= dec_addr;
              reg_wdata <= dec_wdata;
            end else if (reg_ack) begin
              reg_req <= 1'b0;
              if (dec_last) begin
                st <= ST_POLL;
              end else begin
                step <= step + STEP_W'(1);
              end
            end
          end
          ST_POLL: begin
            if (!reg_req) begin
              reg_req   <= 1'b1;
              reg_we    <= 1'b0;
              reg_addr  <= ADR_STATUS;
              reg_wdata <= '0;
            end else if (reg_ack) begin
              reg_req <= 1'b0;
              if (flag_seen) begin
                stat_q <= reg_rdata;
                step   <= '0;
                st     <= rd_q ? ST_FETCH : ST_ACK;
              end else begin
                tries <= tries + TRY_W'(1);
                st    <= ST_GAP;
              end
            end
          end
          ST_GAP: begin
            if (gap_expired) begin
              st <= ST_POLL;
            end
          end
          ST_FETCH: begin
            if (!reg_req) begin
              reg_req   <= 1'b1;
              reg_we    <= 1'b0;
              reg_addr  <= ADR_OUT_LO + 8'(step);
              reg_wdata <= '0;
            end else if (reg_ack) begin
              reg_req <= 1'b0;
              step    <= step + STEP_W'(1);
              if (step == STEP_W'(NBYTES - 1)) begin
                st <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (!reg_req) begin
              reg_req   <= 1'b1;
              reg_we    <= 1'b1;
              reg_addr  <= ADR_STATUS;
              reg_wdata <= stat_q | (8'h01 << FLAG_BIT);
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mbox_seq_chk.sv
module mbox_seq_chk #(
  parameter int OPND_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              err_bus,
  input logic              err_timeout,
  input logic [OPND_W-1:0] result,
  input logic              reg_req,
  input logic              reg_we,
  input logic [7:0]        reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              reg_ack,
  input logic              reg_err
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R1
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R1
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !reg_req); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr)
                               && $stable(reg_we) && $stable(reg_wdata))); // R3
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (reg_req && reg_ack) |=> !reg_req); // R3
  AST_BUS_ABORT: assert property (@(posedge clk) disable iff (rst)
    (done && err_bus) |-> $past(reg_ack && reg_err)); // R8
  AST_TIMEOUT_ON_POLL: assert property (@(posedge clk) disable iff (rst)
    (done && err_timeout) |-> $past(reg_ack && !reg_err && !reg_we
                                    && reg_addr == 8'h02)); // R5
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    (err_bus || err_timeout) |-> done); // R9
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    done |-> !(err_bus && err_timeout)); // R9
  AST_ERR_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
    (done && (err_bus || err_timeout)) |-> (result == '0)); // R9

endmodule

bind mbox_seq mbox_seq_chk #(.OPND_W(OPND_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .done        (done),
  .err_bus     (err_bus),
  .err_timeout (err_timeout),
  .result      (result),
  .reg_req     (reg_req),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_ack     (reg_ack),
  .reg_err     (reg_err)
);

// File: tb/mbox_seq_bench.sv
module mbox_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int GAP_W      = 16;
  localparam int LAT        = 2;
  localparam int GAP        = 20;

  typedef struct packed {
    logic [7:0]  code;
    logic [31:0] opnd;
    logic        rd;
    logic [3:0]  ready_after;
    logic [7:0]  err_addr;
    logic [31:0] outval;
    logic        exp_be;
    logic        exp_to;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h02, 32'h1234ABCD, 1'b0, 4'd0,  8'hFF, 32'h0,        1'b0, 1'b0},
    '{8'h01, 32'h00000000, 1'b1, 4'd3,  8'hFF, 32'hDEADBEEF, 1'b0, 1'b0},
    '{8'h03, 32'h55AA0F0F, 1'b1, 4'd10, 8'hFF, 32'h00C0FFEE, 1'b0, 1'b0},
    '{8'h04, 32'h00000001, 1'b1, 4'd11, 8'hFF, 32'h11111111, 1'b0, 1'b1},
    '{8'h01, 32'hCAFEF00D, 1'b1, 4'd0,  8'h3A, 32'h22222222, 1'b1, 1'b0},
    '{8'h03, 32'h0,        1'b1, 4'd1,  8'h33, 32'h33333333, 1'b1, 1'b0},
    '{8'h02, 32'h00000064, 1'b0, 4'd0,  8'h02, 32'h0,        1'b1, 1'b0},
    '{8'h01, 32'h0,        1'b1, 4'd0,  8'h3F, 32'h44444444, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic [31:0] cmd_opnd = '0;
  logic        cmd_read = 1'b0;
  logic [GAP_W-1:0] poll_gap = GAP_W'(GAP);
  logic        busy, done, err_bus, err_timeout;
  logic [31:0] result;
  logic        reg_req, reg_we;
  logic [7:0]  reg_addr, reg_wdata;
  logic        reg_ack = 1'b0;
  logic        reg_err = 1'b0;
  logic [7:0]  reg_rdata = '0;

  int checks = 0;
  int fails  = 0;

  // configuration of the responder model, written by the stimulus process
  logic        clr_req = 1'b0;
  logic [3:0]  cfg_ready = '0;
  logic [7:0]  cfg_err = 8'hFF;
  logic [31:0] cfg_out = '0;

  // responder state, written only by the responder process
  logic [7:0]  mem [256];
  logic [7:0]  log_a [64];
  logic [7:0]  log_d [64];
  logic        log_w [64];
  int          n_acc, n_stat, n_out, n_clr, lat_cnt, cyc, last_ack, min_gap, max_gap;
  logic        rung, flag;
  logic [7:0]  clr_val;
  logic        seen_req;

  mbox_seq #(.GAP_W(GAP_W)) u_mbox_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_opnd(cmd_opnd), .cmd_read(cmd_read), .poll_gap(poll_gap),
    .busy(busy), .done(done), .err_bus(err_bus), .err_timeout(err_timeout),
    .result(result), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_err(reg_err),
    .reg_rdata(reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    reg_ack <= 1'b0;
    reg_err <= 1'b0;
    if (clr_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      n_acc <= 0; n_stat <= 0; n_out <= 0; n_clr <= 0; lat_cnt <= 0;
      rung <= 1'b0; flag <= 1'b0; clr_val <= 8'h00; seen_req <= 1'b0;
      last_ack <= -1; min_gap <= 1000000; max_gap <= 0;
    end else if (reg_req && !reg_ack) begin
      if (!seen_req && reg_addr == 8'h02 && !reg_we && last_ack >= 0) begin
        if (cyc - last_ack < min_gap) min_gap <= cyc - last_ack;
        if (cyc - last_ack > max_gap) max_gap <= cyc - last_ack;
      end
      seen_req <= 1'b1;
      if (lat_cnt == LAT) begin
        lat_cnt <= 0;
        seen_req <= 1'b0;
        reg_ack <= 1'b1;
        if (n_acc < 64) begin
          log_a[n_acc] <= reg_addr; log_d[n_acc] <= reg_wdata; log_w[n_acc] <= reg_we;
        end
        n_acc <= n_acc + 1;
        if (reg_addr == cfg_err) begin
          reg_err <= 1'b1;
        end else if (reg_we) begin
          mem[reg_addr] <= reg_wdata;
          if (reg_addr == 8'h40) rung <= 1'b1;
          if (reg_addr == 8'h02) begin
            n_clr <= n_clr + 1;
            clr_val <= reg_wdata;
            if (reg_wdata[1]) flag <= 1'b0;
          end
        end else if (reg_addr == 8'h02) begin
          reg_rdata <= 8'h05 | ((rung && n_stat >= int'(cfg_ready)) ? 8'h02 : 8'h00);
          n_stat <= n_stat + 1;
          last_ack <= cyc;
          if (rung && n_stat >= int'(cfg_ready)) flag <= 1'b1;
        end else if (reg_addr >= 8'h31 && reg_addr <= 8'h34) begin
          reg_rdata <= cfg_out[8*(reg_addr-8'h31) +: 8];
          n_out <= n_out + 1;
        end else begin
          reg_rdata <= 8'h00;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic model_clear(input logic [3:0] ready, input logic [7:0] ea,
                             input logic [31:0] ov);
    @(negedge clk);
    cfg_ready = ready; cfg_err = ea; cfg_out = ov; clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
  endtask

  task automatic issue(input logic [7:0] c, input logic [31:0] o, input logic r);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c; cmd_opnd = o; cmd_read = r;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    // R9 R1: reset state
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 done after reset", 32'(done), 32'd0);
    chk("R3 req after reset", 32'(reg_req), 32'd0);
    chk("R9 result after reset", result, 32'd0);
    rst = 1'b0;
    model_clear(4'd0, 8'hFF, 32'h0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic ok;
      t = VECS[v];
      ok = !t.exp_be && !t.exp_to;
      model_clear(t.ready_after, t.err_addr, t.outval);
      issue(t.code, t.opnd, t.rd);
      chk("R1 busy after accept", 32'(busy), 32'd1);
      wait_done(w);
      chk("R1 done pulse seen", 32'(done), 32'd1);
      chk("R1 busy low at done", 32'(busy), 32'd0);
      chk("R8 err_bus", 32'(err_bus), 32'(t.exp_be));
      chk("R5 err_timeout", 32'(err_timeout), 32'(t.exp_to));
      chk("R9 R6 result", result, (ok && t.rd) ? t.outval : 32'h0);
      @(negedge clk);
      chk("R1 done one cycle", 32'(done), 32'd0);
      chk("R9 flags cleared", 32'(err_bus | err_timeout), 32'd0);
      if (!t.exp_be || n_acc >= 7) begin
        // R2: load order
        chk("R2 arm addr", 32'(log_a[0]), 32'h3F);
        chk("R2 arm data", 32'(log_d[0]), 32'h80);
        chk("R2 cmd", {log_a[1], log_d[1]}, {8'h38, t.code});
        for (int i = 0; i < 4; i++)
          chk("R2 operand byte", {log_a[2+i], log_d[2+i]},
              {8'h39 + 8'(i), t.opnd[8*i +: 8]});
        chk("R2 doorbell", {log_a[6], log_d[6], 7'd0, log_w[6]}, {8'h40, 8'h01, 8'd1});
      end
      if (ok) begin
        chk("R6 result reads", n_out, t.rd ? 4 : 0);
        chk("R7 ack count", n_clr, 1);
        chk("R7 ack value", 32'(clr_val), 32'h07);
        chk("R7 flag cleared", 32'(flag), 32'd0);
        chk("R4 status polls", n_stat, int'(t.ready_after) + 1);
        if (t.ready_after != 0) begin
          chk("R4 min gap", 32'(min_gap >= GAP), 32'd1);
          chk("R4 max gap", 32'(max_gap <= GAP + 4), 32'd1);
        end
        if (t.rd) begin
          for (int i = 0; i < 4; i++)
            chk("R6 read order", 32'(log_a[7 + n_stat + i]), 32'h31 + i);
        end
      end
      if (t.exp_to) begin
        chk("R5 poll count", n_stat, 11);
        chk("R5 no result reads", n_out, 0);
        chk("R5 no ack write", n_clr, 0);
      end
      if (t.exp_be) begin
        chk("R8 last access is failing one", 32'(log_a[n_acc-1]), 32'(t.err_addr));
        chk("R8 no ack write", n_clr, (t.err_addr == 8'h02 && log_w[n_acc-1]) ? 1 : 0);
        repeat (5) @(negedge clk);
        chk("R8 no access after error", 32'(reg_req), 32'd0);
      end
    end

    // R1: a request while busy is ignored
    model_clear(4'd2, 8'hFF, 32'h0);
    issue(8'h02, 32'h000000AA, 1'b0);
    issue(8'h77, 32'hFFFFFFFF, 1'b1);
    wait_done(w);
    chk("R1 done for first request", 32'(done), 32'd1);
    chk("R1 second cmd ignored", 32'(mem[8'h38]), 32'h02);
    chk("R1 second operand ignored", 32'(mem[8'h39]), 32'hAA);
    repeat (30) @(negedge clk);
    chk("R1 no second run", 32'(busy | reg_req), 32'd0);
    chk("R1 single load", n_acc, 7 + 3 + 1);

    // R4: zero gap still completes
    poll_gap = '0;
    model_clear(4'd4, 8'hFF, 32'h89ABCDEF);
    issue(8'h03, 32'h0, 1'b1);
    wait_done(w);
    chk("R4 zero gap result", result, 32'h89ABCDEF);
    chk("R4 zero gap polls", n_stat, 5);

    finish_run();
  end

endmodule